// File: doc/BRIEF.md
# Dual-Rate Parallel-to-Serial Converter

The block takes an 8-bit parallel word, stores it, and sends it out as a one-bit NRZ stream. Bit 0 goes first and the highest-numbered bit goes last. A rate select picks one of two speeds. At single rate one bit goes out per clock cycle. At double rate two bits go out per cycle: one in the low half of the clock and one in the high half. The stored word, the bit counter and the mode all update on the rising clock edge. The bits that drive the output are picked on the falling edge.

A word-rate clock output tells upstream logic when a word has been taken. It rises on the rising edge that captures a word and stays high for the first half of the word period. Upstream logic changes the parallel input after that rising edge.

An asynchronous synchronize input clears the sequencing at once, whatever the clock is doing. A clock enable freezes the sequencing. A change of rate select only takes effect when the next word is captured.

Top module: `dr_serializer`

## Requirements
- R1: With `rate_i`=0 (single rate), the word's bits leave in index order 0,1,...,7. Each bit is held on `ser_o` for one full clock period, from one falling edge to the next. Bit 0 appears at the falling edge that follows the capturing rising edge.
- R2: With `rate_i`=1 (double rate), pair k (0..3) is shown in the clock period that starts at a falling edge. Bit 2k is on `ser_o` while `clk` is low, then bit 2k+1 while `clk` is high. Pair 0 starts at the falling edge that follows the capturing rising edge.
- R3: Once a first word has been taken, the next word is captured exactly 8 enabled rising edges later at single rate, or 4 at double rate. Values on `par_i` between captures have no effect on `ser_o`.
- R4: `rate_i` is sampled only on a capturing rising edge, and that value sets the mode for the whole word. Changes of `rate_i` between captures have no effect on `ser_o`.
- R5: `wclk_o` goes to 1 on each capturing rising edge and stays 1 for the first half of the word period. That is 4 enabled rising edges at single rate and 2 at double rate. It is 0 for the rest of the period.
- R6: While `sync_i` is 1, `ser_o` and `wclk_o` are 0, and they drop right away without waiting for a clock edge.
- R7: After `sync_i` or `rst_n` is released, the first rising edge with `en_i`=1 captures a word. `ser_o` stays 0 until the falling edge after that capture.
- R8: On a rising edge with `en_i`=0 there is no capture and no advance. `ser_o` keeps the level it last showed, and `wclk_o` keeps its level.
- R9: `rst_n`=0 on a rising edge clears the sequencing. `wclk_o` is 0 from that edge. `ser_o` is 0 from the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; storage updates on the rising edge, output bits are picked on the falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_i | input | 1 | Asynchronous synchronize/clear, active high |
| en_i | input | 1 | Clock enable for the sequencing |
| rate_i | input | 1 | 0 = one bit per clock, 1 = two bits per clock |
| par_i | input | 8 | Parallel word; bit 0 is sent first |
| ser_o | output | 1 | Serial NRZ data |
| wclk_o | output | 1 | Word-rate clock; rises on each capture edge |

## Verification
The bench counts latency from the capturing rising edge. The first serial bit is due at the falling edge half a period after that edge, and in single rate each bit is then valid for a full period. The scoreboard pushes its expected bits 3 ns after the capture edge. The monitor compares 2 ns after each falling edge and 2 ns after each rising edge, so every double-rate bit is checked once and every single-rate bit twice. `wclk_o` settles within each edge's own cycle and is checked 1 ns after the edge. The enable-stall and reset cases are timed by hand against the same edge count.

// File: rtl/ser_pkg.sv
`timescale 1ns/1ps
// Shared types for the dual-rate serializer.
package ser_pkg;
    // Serialization rate captured with each word.
    typedef enum logic {
        RATE_SGL = 1'b0,
        RATE_DBL = 1'b1
    } rate_e;
endpackage

// File: rtl/ser_word_ctl.sv
`timescale 1ns/1ps
// Word capture and bit sequencing, rising-edge domain.
// What it does: holds the captured word, the bit or pair index, and the
// word's mode. It reports whether the last rising edge advanced, and it
// derives the word-rate clock.
// Assumes: WORD_W is a multiple of 4. sync_i is an asynchronous active-high
// clear. rst_n is synchronous and active low.
module ser_word_ctl
    import ser_pkg::*;
#(
    parameter  int WORD_W = 8,
    localparam int IDX_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic              en_i,
    input  logic              rate_i,
    input  logic [WORD_W-1:0] par_i,
    output logic [WORD_W-1:0] word_q,
    output logic [IDX_W-1:0]  idx_q,
    output rate_e             mode_q,
    output logic              live_q,
    output logic              step_q,
    output logic              wclk_o
);
    localparam logic [IDX_W-1:0] LAST_S = IDX_W'(WORD_W - 1);
    localparam logic [IDX_W-1:0] LAST_D = IDX_W'(WORD_W/2 - 1);
    localparam logic [IDX_W-1:0] HALF_S = IDX_W'(WORD_W/2);
    localparam logic [IDX_W-1:0] HALF_D = IDX_W'(WORD_W/4);

    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] half_idx;
    logic             at_end;
    logic             load;

    // Pick the final index and the half-period point for the word's mode.
    always_comb begin
        last_idx = (mode_q == RATE_DBL) ? LAST_D : LAST_S;
        half_idx = (mode_q == RATE_DBL) ? HALF_D : HALF_S;
        at_end   = (idx_q == last_idx);
        load     = !live_q || at_end;
    end

    // Capture a word or advance the index on each enabled rising edge.
    always_ff @(posedge clk or posedge sync_i) begin
        if (sync_i) begin
            word_q <= '0;
            idx_q  <= '0;
            mode_q <= RATE_SGL;
            live_q <= 1'b0;
            step_q <= 1'b0;
        end else if (!rst_n) begin
            word_q <= '0;
            idx_q  <= '0;
            mode_q <= RATE_SGL;
            live_q <= 1'b0;
            step_q <= 1'b0;
        end else begin
            step_q <= en_i;
            if (en_i) begin
                if (load) begin
                    word_q <= par_i;
                    mode_q <= rate_e'(rate_i);
                    idx_q  <= '0;
                    live_q <= 1'b1;
                end else begin
                    idx_q  <= idx_q + 1'b1;
                end
            end
        end
    end

    // The word-rate clock is high during the first half of each word.
    assign wclk_o = live_q && (idx_q < half_idx);

    // A mode change happens only on a capturing edge.
    assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n || sync_i)
        (live_q && !(en_i && at_end)) |=> $stable(mode_q));

    // After a clear, the first enabled edge starts a word at index 0.
    assert_first_take_R7: assert property (@(posedge clk) disable iff (!rst_n || sync_i)
        (!live_q && en_i) |=> (live_q && idx_q == '0));

    // With the enable low, the word and the index stay frozen.
    assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n || sync_i)
        (live_q && !en_i) |=> ($stable(idx_q) && $stable(word_q)));
endmodule

// File: rtl/ser_bit_pick.sv
`timescale 1ns/1ps
// Output bit selection, falling-edge domain.
// What it does: on each falling edge that follows an advancing rising edge,
// it loads the bit for the low clock half (lo_q) and for the high clock half
// (hi_q). At single rate both hold the same bit. At double rate they hold
// the even and odd bit of the current pair. After a stalled rising edge it
// copies hi_q into lo_q, so the output keeps its last level.
// Assumes: the index input is stable between rising edges.
module ser_bit_pick
    import ser_pkg::*;
#(
    parameter  int WORD_W = 8,
    localparam int IDX_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  rate_e             mode_i,
    input  logic              step_i,
    input  logic              live_i,
    output logic              lo_q,
    output logic              hi_q
);
    logic [IDX_W-1:0] ev_sel;
    logic [IDX_W-1:0] od_sel;
    logic             sgl_bit;
    logic             ev_bit;
    logic             od_bit;

    // Work out the single-rate bit and the even/odd pair bits for the index.
    always_comb begin
        ev_sel  = {idx_i[IDX_W-2:0], 1'b0};
        od_sel  = {idx_i[IDX_W-2:0], 1'b1};
        sgl_bit = word_i[idx_i];
        ev_bit  = word_i[ev_sel];
        od_bit  = word_i[od_sel];
    end

    // Update the two half-period bits on the falling edge.
    always_ff @(negedge clk or posedge sync_i) begin
        if (sync_i) begin
            lo_q <= 1'b0;
            hi_q <= 1'b0;
        end else if (!rst_n || !live_i) begin
            lo_q <= 1'b0;
            hi_q <= 1'b0;
        end else if (step_i) begin
            lo_q <= (mode_i == RATE_DBL) ? ev_bit : sgl_bit;
            hi_q <= (mode_i == RATE_DBL) ? od_bit : sgl_bit;
        end else begin
            lo_q <= hi_q;
        end
    end
endmodule

// File: rtl/dr_serializer.sv
`timescale 1ns/1ps
// Dual-rate parallel-to-serial converter, top level.
// What it does: captures a parallel word and sends it out LSB first, at one
// or two bits per clock. Storage updates on the rising edge and bits are
// picked on the falling edge. The clock level steers the output between the
// low-half bit and the high-half bit.
// Assumes: a free-running clk. rate_i is only looked at when a word is
// captured.
module dr_serializer
    import ser_pkg::*;
#(
    parameter  int WORD_W = 8,
    localparam int IDX_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic              en_i,
    input  logic              rate_i,
    input  logic [WORD_W-1:0] par_i,
    output logic              ser_o,
    output logic              wclk_o
);
    logic [WORD_W-1:0] word_q;
    logic [IDX_W-1:0]  idx_q;
    rate_e             mode_q;
    logic              live_q;
    logic              step_q;
    logic              lo_q;
    logic              hi_q;

    ser_word_ctl #(.WORD_W(WORD_W)) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_i),
        .en_i   (en_i),
        .rate_i (rate_i),
        .par_i  (par_i),
        .word_q (word_q),
        .idx_q  (idx_q),
        .mode_q (mode_q),
        .live_q (live_q),
        .step_q (step_q),
        .wclk_o (wclk_o)
    );

    ser_bit_pick #(.WORD_W(WORD_W)) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_i),
        .word_i (word_q),
        .idx_i  (idx_q),
        .mode_i (mode_q),
        .step_i (step_q),
        .live_i (live_q),
        .lo_q   (lo_q),
        .hi_q   (hi_q)
    );

    // Drive the low-half bit while clk is low and the high-half bit while it is high.
    assign ser_o = clk ? hi_q : lo_q;

    // While synchronize is held, the output is low.
    assert_sync_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |-> (!ser_o && !wclk_o));

    // Before the first word is taken, the output rests low.
    assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n || sync_i)
        (!live_q && $past(!live_q)) |-> !ser_o);
endmodule

// File: tb/sim_dr_serializer.sv
`timescale 1ns/1ps
module sim_dr_serializer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_i = 1'b0;
    logic       en_i = 1'b1;
    logic       rate_i = 1'b0;
    logic [7:0] par_i = 8'h00;
    logic       ser_o;
    logic       wclk_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic  exp_q[$];
    string tag_q[$];

    dr_serializer u0 (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .en_i(en_i),
        .rate_i(rate_i), .par_i(par_i), .ser_o(ser_o), .wclk_o(wclk_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // Monitor: sample 2 ns after each falling and each rising edge, and pop when an item is pending.
    initial begin
        forever begin
            @(negedge clk); #2;
            if (exp_q.size() > 0) chk({7'd0, ser_o}, {7'd0, exp_q.pop_front()}, tag_q.pop_front());
            @(posedge clk); #2;
            if (exp_q.size() > 0) chk({7'd0, ser_o}, {7'd0, exp_q.pop_front()}, tag_q.pop_front());
        end
    end

    // Driver: call 1 ns after the rising edge that comes before a capture.
    task automatic send_word(input logic [7:0] w, input logic m, input bit first);
        int n;
        n = m ? 4 : 8;
        par_i  = w;
        rate_i = m;
        @(posedge clk); #1;
        if (first) chk({7'd0, ser_o}, 8'd0, "R7 low until first bit");
        par_i  = ~w;      // R3: ignored until the next capture
        rate_i = ~m;      // R4: ignored until the next capture
        #2;
        chk({7'd0, wclk_o}, 8'd1, "R5 wclk high at capture");
        for (int b = 0; b < 8; b++) begin
            exp_q.push_back(w[b]);
            tag_q.push_back(m ? "R2,R3,R4 double bit" : "R1,R3,R4 single bit");
            if (!m) begin
                exp_q.push_back(w[b]);
                tag_q.push_back("R1 single bit full period");
            end
        end
        for (int i = 1; i < n; i++) begin
            @(posedge clk); #1;
            chk({7'd0, wclk_o}, {7'd0, (i < n/2)}, "R5 wclk phase");
        end
    endtask

    initial begin
        // R9: reset state
        repeat (4) @(posedge clk);
        #1;
        chk({7'd0, ser_o}, 8'd0, "R9 ser after reset");
        chk({7'd0, wclk_o}, 8'd0, "R9 wclk after reset");
        sync_i = 1'b1;
        rst_n  = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk({7'd0, ser_o}, 8'd0, "R6 ser while sync");
        chk({7'd0, wclk_o}, 8'd0, "R6 wclk while sync");
        sync_i = 1'b0;
        send_word(8'hFF, 1'b0, 1'b1);
        send_word(8'hA5, 1'b0, 1'b0);
        send_word(8'h3C, 1'b0, 1'b0);
        send_word(8'h96, 1'b1, 1'b0);
        send_word(8'hF0, 1'b1, 1'b0);
        send_word(8'h01, 1'b0, 1'b0);
        send_word(8'h0F, 1'b1, 1'b0);
        send_word(8'h5A, 1'b1, 1'b0);
        send_word(8'h80, 1'b0, 1'b0);
        send_word(8'hC3, 1'b1, 1'b0);
        par_i  = 8'hFF;
        rate_i = 1'b0;
        repeat (12) @(posedge clk);
        #2;
        chk({7'd0, ser_o}, 8'd1, "R1 all-ones word");
        // R6: asynchronous clear in the middle of the low clock half
        @(negedge clk); #2;
        sync_i = 1'b1;
        #1;
        chk({7'd0, ser_o}, 8'd0, "R6 ser drops without edge");
        chk({7'd0, wclk_o}, 8'd0, "R6 wclk drops without edge");
        repeat (2) @(posedge clk);
        #1;
        // R8: enable stall on word 0x34 (bits 0,0,1,0,1,1,0,0), single rate
        sync_i = 1'b0;
        par_i  = 8'h34;
        rate_i = 1'b0;
        @(posedge clk); #1;   // E0 capture
        par_i = 8'h00;
        @(posedge clk); #1;   // E1
        @(posedge clk); #1;   // E2: bit 2 is next
        en_i = 1'b0;
        @(posedge clk); #2;   // E3 stalled
        chk({7'd0, ser_o}, 8'd1, "R8 hold high half");
        @(negedge clk); #2;
        chk({7'd0, ser_o}, 8'd1, "R8 hold low half");
        @(posedge clk); #2;   // E4 stalled
        chk({7'd0, wclk_o}, 8'd1, "R8 wclk held");
        @(posedge clk); #1;   // E5 stalled
        en_i = 1'b1;
        #1;
        chk({7'd0, ser_o}, 8'd1, "R8 hold before resume");
        @(negedge clk); #2;
        chk({7'd0, ser_o}, 8'd1, "R8 hold after last stalled edge");
        @(posedge clk); #2;   // E6 advances to bit 3
        chk({7'd0, ser_o}, 8'd1, "R8 bit 2 still shown");
        @(negedge clk); #2;
        chk({7'd0, ser_o}, 8'd0, "R8,R1 resumed bit 3");
        @(posedge clk); #2;   // E7 index 4
        chk({7'd0, wclk_o}, 8'd0, "R5 wclk low in second half");
        @(negedge clk); #2;
        chk({7'd0, ser_o}, 8'd1, "R1 bit 4");
        // R9: synchronous reset in mid-word
        @(posedge clk); #1;
        rst_n = 1'b0;
        @(posedge clk); #2;
        chk({7'd0, wclk_o}, 8'd0, "R9 wclk cleared at edge");
        @(negedge clk); #2;
        chk({7'd0, ser_o}, 8'd0, "R9 ser cleared at falling edge");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog at %0t: got hang expected finish", $time);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule